// File: doc/BRIEF.md
# HDLC Receive Byte Buffer

This block sits after an HDLC deframer on the receive side. The deframer supplies one data bit per valid cycle and marks the first bit of each packet. The block can invert each bit and can place the first bit of a byte at either end of that byte. It packs the bits into bytes and stores them in a 256-entry buffer. A host drains the buffer one byte per valid/ready handshake.

The block reports four status flags: empty, full, a sticky overflow, and data-available. Data-available compares the stored count with a programmable threshold counted in units of eight bytes.

A flush control empties the buffer and drops everything while it is held. After the flush is released, nothing is stored until the next packet-start marker arrives. Each stored byte carries one attribute bit. That bit records whether its packet was declared to carry a frame check sequence.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: The buffer holds 256 bytes. `st_full` is 1 exactly when 256 bytes are stored, and 0 when 255 or fewer are stored.
- R2: `st_empty` is 1 when no byte is stored and 0 when at least one byte is stored.
- R3: `st_avail` is 1 when the stored count is at least 8 × `ctl_level` (5-bit field, so level 2 means 16 bytes), and 0 otherwise. While `ctl_flush` is 1, `st_avail` is 0.
- R4: With `ctl_msb_first` = 0, the first bit of a byte lands in bit 0 of `rd_data`. With `ctl_msb_first` = 1, it lands in bit 7.
- R5: With `ctl_invert` = 1, every bit is complemented before packing. With `ctl_invert` = 0, bits are stored unchanged.
- R6: While `ctl_flush` is 1, the following all happen:
  - the stored count drops to 0;
  - a partly packed byte is abandoned;
  - all input is dropped;
  - the overflow flag clears.
- R7: After reset, and after `ctl_flush` returns to 0, input bits are dropped until a bit arrives with `in_valid` and `in_sop` both 1. That bit is the first bit of a new byte.
- R8: A byte that completes while 256 bytes are stored is dropped and sets `st_overflow`. The flag stays 1 until a flush.
- R9: The read port works as follows:
  - `rd_valid` is 1 whenever the buffer is not empty;
  - `rd_data` shows the oldest byte;
  - a cycle with `rd_valid` and `rd_ready` both 1 removes that byte;
  - a write and a read in the same cycle leave the count unchanged.
- R10: A packet-start bit that arrives in the middle of a byte discards the partial byte. Packing restarts with that bit as bit one.
- R11: `rd_fcs` equals the inverse of `ctl_no_fcs` as sampled on the packet-start bit of the packet that byte belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_flush | input | 1 | Empty the buffer and drop input while 1 |
| ctl_msb_first | input | 1 | First bit goes to bit 7 when 1, bit 0 when 0 |
| ctl_invert | input | 1 | Complement incoming bits |
| ctl_no_fcs | input | 1 | Packet carries no check sequence |
| ctl_level | input | 5 | Data-available threshold in 8-byte groups |
| in_valid | input | 1 | Input bit is valid |
| in_bit | input | 1 | Serial data bit |
| in_sop | input | 1 | Marks the first bit of a packet |
| rd_valid | output | 1 | A byte is available |
| rd_ready | input | 1 | Host accepts the byte |
| rd_data | output | 8 | Oldest stored byte |
| rd_fcs | output | 1 | Check-sequence attribute of that byte |
| st_empty | output | 1 | No byte stored |
| st_full | output | 1 | 256 bytes stored |
| st_avail | output | 1 | Stored count at or above threshold |
| st_overflow | output | 1 | Sticky: a byte was dropped because the buffer was full |

## Verification
The bench builds the block with its default parameters: 8 address bits (256 bytes) and a 5-bit level field. Filling the buffer to capacity therefore takes about two thousand input cycles, which puts both the full boundary and overflow within reach. The run also pushes one byte past capacity and then drains all 256 bytes to confirm that the extra byte was discarded. Threshold level 2 tests the 15-byte and 16-byte edges. The bench also covers both bit orders, inversion, a mid-byte restart and a flush that arrives during partial packing.

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 5,
  parameter int GRP_LOG2 = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_flush,
  input  logic              ctl_msb_first,
  input  logic              ctl_invert,
  input  logic              ctl_no_fcs,
  input  logic [LVL_W-1:0]  ctl_level,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              in_sop,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_fcs,
  output logic              st_empty,
  output logic              st_full,
  output logic              st_avail,
  output logic              st_overflow
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam int BC_W  = $clog2(BYTE_W);
  localparam int THR_W = LVL_W + GRP_LOG2;

  logic [BYTE_W:0]    mem [DEPTH];
  logic [ADDR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sh;
  logic [BC_W-1:0]    bc;
  logic               armed, pkt_fcs, ovf;

  wire b    = in_bit ^ ctl_invert;
  wire take = in_valid && !ctl_flush && (armed || in_sop);
  wire [BYTE_W-1:0] base = in_sop ? '0 : sh;
  wire [BYTE_W-1:0] sh_nx = ctl_msb_first ? {base[BYTE_W-2:0], b} : {b, base[BYTE_W-1:1]};
  wire [BC_W-1:0] bc_cur = in_sop ? '0 : bc;
  wire done    = take && (bc_cur == BC_W'(BYTE_W-1));
  wire fcs_cur = in_sop ? !ctl_no_fcs : pkt_fcs;
  wire full    = (cnt == CNT_W'(DEPTH));
  wire wr      = done && !full;
  wire rd      = rd_valid && rd_ready && !ctl_flush;
  wire [THR_W-1:0] thr = {ctl_level, {GRP_LOG2{1'b0}}};

  assign rd_valid    = (cnt != '0);
  assign rd_data     = mem[rp][BYTE_W-1:0];
  assign rd_fcs      = mem[rp][BYTE_W];
  assign st_empty    = (cnt == '0);
  assign st_full     = full;
  assign st_avail    = !ctl_flush && ({{(CNT_W > THR_W ? CNT_W : THR_W){1'b0}}, cnt} >= {{(CNT_W > THR_W ? CNT_W : THR_W){1'b0}}, thr});
  assign st_overflow = ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; sh <= '0; bc <= '0;
      armed <= 1'b0; pkt_fcs <= 1'b0; ovf <= 1'b0;
    end else if (ctl_flush) begin
      wp <= '0; rp <= '0; cnt <= '0; bc <= '0;
      armed <= 1'b0; ovf <= 1'b0;
    end else begin
      if (take) begin
        armed   <= 1'b1;
        sh      <= sh_nx;
        bc      <= done ? '0 : bc_cur + 1'b1;
        pkt_fcs <= fcs_cur;
      end
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
      if (done && full) ovf <= 1'b1;
      case ({wr, rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= {fcs_cur, sh_nx};
  end

  p_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_flush |=> (cnt == '0) && !st_overflow && !rd_valid);
  p_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !(in_valid && in_sop)) |=> cnt <= $past(cnt));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overflow && !ctl_flush) |=> st_overflow);
  p_rw_same_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rd) |=> cnt == $past(cnt));
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_flush) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt + 1'b1 == $past(cnt)));
endmodule

// File: tb/sim_hdlc_rx_fifo.sv
module sim_hdlc_rx_fifo;
  logic clk = 0, rst_n = 0;
  logic ctl_flush = 0, ctl_msb_first = 0, ctl_invert = 0, ctl_no_fcs = 0;
  logic [4:0] ctl_level = 5'd1;
  logic in_valid = 0, in_bit = 0, in_sop = 0, rd_ready;
  logic rd_valid, rd_fcs, st_empty, st_full, st_avail, st_overflow;
  logic [7:0] rd_data;
  logic mon_en = 0;
  int checks = 0, failures = 0, cycles = 0;
  logic [8:0] q[$];

  always #2.5 clk = ~clk;
  assign rd_ready = mon_en;

  hdlc_rx_fifo u0 (.clk, .rst_n, .ctl_flush, .ctl_msb_first, .ctl_invert, .ctl_no_fcs,
    .ctl_level, .in_valid, .in_bit, .in_sop, .rd_valid, .rd_ready, .rd_data, .rd_fcs,
    .st_empty, .st_full, .st_avail, .st_overflow);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_byte(logic [7:0] raw, logic msb, logic inv);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = msb ? raw[7-i] : raw[i];
    return v ^ {8{inv}};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send_bits(logic [7:0] raw, int n, logic sop);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_bit = raw[i]; in_sop = sop && (i == 0);
      step();
    end
    in_valid = 0; in_sop = 0;
  endtask

  task automatic send_byte(logic [7:0] raw, logic sop, logic stored);
    if (sop) begin
      if (stored) q.push_back({!ctl_no_fcs, expect_byte(raw, ctl_msb_first, ctl_invert)});
    end else if (stored) q.push_back({q.size() > 0 ? q[$][8] : !ctl_no_fcs,
                                     expect_byte(raw, ctl_msb_first, ctl_invert)});
    send_bits(raw, 8, sop);
  endtask

  task automatic drain();
    mon_en = 1;
    while (q.size() != 0) step();
    step(); step();
    mon_en = 0;
  endtask

  task automatic flush_pulse();
    ctl_flush = 1; step(); step(); ctl_flush = 0; q.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_en && rd_valid) begin
      if (q.size() == 0) chk("R9 unexpected byte", {23'd0, rd_fcs, rd_data}, 32'h1ff);
      else begin
        logic [8:0] e;
        e = q.pop_front();
        chk("R9 data/attr (R4 R5 R11)", {23'd0, rd_fcs, rd_data}, {23'd0, e});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    @(negedge clk);
    chk("R2 empty after reset", st_empty, 1);
    chk("R1 not full after reset", st_full, 0);
    chk("R3 avail low after reset", st_avail, 0);
    chk("R8 no overflow after reset", st_overflow, 0);
    chk("R9 no valid after reset", rd_valid, 0);

    send_byte(8'hA5, 0, 0); send_byte(8'h3C, 0, 0);
    @(negedge clk);
    chk("R7 hunting drops bits", st_empty, 1);

    send_byte(8'hA5, 1, 1); send_byte(8'h3C, 0, 1);
    @(negedge clk);
    chk("R2 not empty with data", st_empty, 0);
    chk("R3 level1 with 2 bytes", st_avail, 0);
    drain();
    chk("R9 empty after drain", st_empty, 1);

    ctl_msb_first = 1; send_byte(8'h01, 1, 1); send_byte(8'hC8, 0, 1);
    ctl_invert = 1; send_byte(8'h0F, 0, 1);
    ctl_msb_first = 0; send_byte(8'h81, 0, 1);
    ctl_no_fcs = 1; send_byte(8'h5A, 1, 1); ctl_invert = 0; send_byte(8'h77, 0, 1);
    ctl_no_fcs = 0;
    drain();

    send_bits(8'hFF, 3, 1);
    send_byte(8'h12, 1, 1);
    drain();
    chk("R10 restart leaves only one byte", st_empty, 1);

    mon_en = 1;
    send_byte(8'h40, 1, 1);
    for (int i = 0; i < 6; i++) send_byte(8'(i * 37), 0, 1);
    drain();
    chk("R9 concurrent stream drained", st_empty, 1);

    flush_pulse();
    ctl_level = 5'd2;
    send_byte(8'd0, 1, 1);
    for (int i = 1; i < 15; i++) send_byte(8'(i), 0, 1);
    @(negedge clk);
    chk("R3 15 bytes below level 2", st_avail, 0);
    send_byte(8'd15, 0, 1);
    @(negedge clk);
    chk("R3 16 bytes meets level 2", st_avail, 1);
    for (int i = 16; i < 255; i++) send_byte(8'(i), 0, 1);
    @(negedge clk);
    chk("R1 255 bytes not full", st_full, 0);
    send_byte(8'd255, 0, 1);
    @(negedge clk);
    chk("R1 256 bytes full", st_full, 1);
    chk("R8 no overflow at exactly full", st_overflow, 0);
    send_byte(8'hEE, 0, 0);
    @(negedge clk);
    chk("R8 overflow raised", st_overflow, 1);
    chk("R1 still full after drop", st_full, 1);
    drain();
    chk("R8 extra byte was dropped", st_empty, 1);
    chk("R8 overflow sticky", st_overflow, 1);

    ctl_level = 5'd0;
    send_byte(8'h21, 1, 1); send_byte(8'h22, 0, 1);
    send_bits(8'hFF, 3, 0);
    ctl_flush = 1; in_valid = 1; in_bit = 1; step();
    @(negedge clk);
    chk("R6 flush empties", st_empty, 1);
    chk("R6 flush forces avail low", st_avail, 0);
    chk("R6 flush clears overflow", st_overflow, 0);
    in_sop = 1; step(); in_sop = 0; in_valid = 0;
    @(negedge clk);
    chk("R6 input dropped during flush", st_empty, 1);
    ctl_flush = 0; q.delete();
    send_byte(8'h99, 0, 0);
    @(negedge clk);
    chk("R7 no storage before sop after flush", st_empty, 1);
    send_byte(8'h6B, 1, 1);
    @(negedge clk);
    chk("R3 level0 avail with data", st_avail, 1);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule